// File: doc/BRIEF.md
# Synchronisable Fractional Clock-Enable Divider Bank

This block holds one free-running divider for each of several sequencer engines. Each divider emits a single-cycle clock-enable pulse. Its average rate is the system clock divided by a 16.8 fixed-point divisor: a 16-bit integer part and an 8-bit fraction. An 8-bit phase accumulator adds the fraction once per period. When that addition carries, the period lasts one cycle longer. Each engine also has an enable bit. The tick delivered to an engine is the divider pulse gated by that bit. The divider itself never stops when its engine is disabled.

A restart mask clears the cycle counter and the fractional phase of every selected divider on the same clock edge. Dividers that are given equal divisors and restarted together then pulse in lockstep. The sync-enable mask sets the selected enable bits and restarts the same dividers on one edge, which starts several engines in phase.

Each divider is a small state machine. Its states are `DS_IDLE`, `DS_COUNT` and `DS_STRETCH`:
- `DS_IDLE` is entered at reset and emits nothing. It moves to `DS_COUNT` on a restart.
- `DS_COUNT` counts the integer part of the period. On the last count it either pulses and begins a new period (count-to-count), or moves to `DS_STRETCH` when the carry of this period is set.
- `DS_STRETCH` is one extra cycle. It pulses and returns to `DS_COUNT`.
- A restart forces `DS_COUNT` from any state.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, `clk_en_o`, `tick_o` and `eng_en_o` are all 0. A divider produces no pulse until its first restart or sync-enable.
- R2: Call the first cycle after the edge that samples a restart cycle 1. The k-th pulse then appears in cycle k*I + floor(k*F/256), where I is the integer part and F is the fraction. Each pulse lasts exactly one cycle.
- R3: An integer part of 0 counts as 65536, so the first pulse after a restart comes in cycle 65536.
- R4: A divisor of I=1, F=0 produces a pulse in every cycle.
- R5: Take a window of W cycles starting at a restart, with a constant divisor. The number of pulses in it differs from W*256/(I*256+F) by at most one.
- R6: A restart affects only the channels whose bit is set in `restart_i` (bit n selects channel n). All of those channels restart on the same edge. The other channels keep their phase.
- R7: Two channels that hold the same divisor and are restarted on the same edge produce identical `clk_en_o` bits in every later cycle.
- R8: `clk_en_o` does not depend on the enable bits. Disabling a channel and enabling it again leaves its pulse phase unchanged. `tick_o[n]` equals `clk_en_o[n]` AND `eng_en_o[n]`.
- R9: A bit in `en_set_i` sets the enable bit and a bit in `en_clr_i` clears it. The change is visible in the next cycle. If both are set for the same channel, the set wins.
- R10: A bit in `sync_en_i` sets that channel's enable bit and restarts its divider on the same edge.
- R11: A divisor applied while a divider is running takes effect at the next period boundary, meaning the edge that ends a pulse cycle. A divisor applied together with a restart takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_int_i | input | N_CH*INT_W | Integer part of each channel's divisor (0 means 65536) |
| div_frac_i | input | N_CH*FRAC_W | Fractional part of each channel's divisor, in 1/256 steps |
| restart_i | input | N_CH | Phase restart mask, one bit per channel |
| en_set_i | input | N_CH | Enable-set mask |
| en_clr_i | input | N_CH | Enable-clear mask |
| sync_en_i | input | N_CH | Enable-and-restart mask |
| clk_en_o | output | N_CH | Free-running divider pulse per channel |
| tick_o | output | N_CH | Divider pulse gated by the engine enable |
| eng_en_o | output | N_CH | Current engine enable bits |

## Verification
A wrong phase counter or a lost fractional carry shows up as a `clk_en_o` pulse one cycle early or late. The error appears at the first period whose carry differs from the closed-form schedule, which is at most 256 periods after a restart. A corrupted restart path shows at once in cycle 1: a divisor of 1 must pulse there and any other divisor must not. Two lockstepped channels that drift apart differ on `clk_en_o` at their next boundary. An enable that leaks into the divider shifts the pulses seen after a re-enable.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Per-channel divider phase
    typedef enum logic [1:0] {
        DS_IDLE    = 2'd0,
        DS_COUNT   = 2'd1,
        DS_STRETCH = 2'd2
    } div_state_e;

endpackage

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              pulse_o
);

    div_state_e        state_q, state_d;
    logic [INT_W-1:0]  cnt_q;
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] acc_q;
    logic              stretch_q;

    logic [INT_W-1:0]  last_cnt;
    logic              at_end;
    logic [FRAC_W:0]   acc_sum;

    // Integer part of 0 wraps to the full 2^INT_W count
    assign last_cnt = int_q - INT_W'(1);
    assign at_end   = (cnt_q == last_cnt);
    assign acc_sum  = {1'b0, acc_q} + {1'b0, div_frac_i};

    // Output decode
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            DS_IDLE:    pulse_o = 1'b0;
            DS_COUNT:   pulse_o = at_end && !stretch_q;
            DS_STRETCH: pulse_o = 1'b1;
            default:    pulse_o = 1'b0;
        endcase
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = DS_COUNT;
        end else begin
            unique case (state_q)
                DS_IDLE:    state_d = DS_IDLE;
                DS_COUNT:   state_d = (at_end && stretch_q) ? DS_STRETCH : DS_COUNT;
                DS_STRETCH: state_d = DS_COUNT;
                default:    state_d = DS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= DS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Period counter, divisor latch and fractional phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q     <= '0;
            int_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (restart_i) begin
            // first period: phase 0 plus fraction never carries
            cnt_q     <= '0;
            int_q     <= div_int_i;
            acc_q     <= div_frac_i;
            stretch_q <= 1'b0;
        end else if (pulse_o) begin
            cnt_q     <= '0;
            int_q     <= div_int_i;
            acc_q     <= acc_sum[FRAC_W-1:0];
            stretch_q <= acc_sum[FRAC_W];
        end else if (state_q == DS_COUNT && !at_end) begin
            cnt_q     <= cnt_q + INT_W'(1);
        end
    end

endmodule

// File: rtl/clkdiv_enable.sv
module clkdiv_enable #(
    parameter int N_CH = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_CH-1:0] set_i,
    input  logic [N_CH-1:0] clr_i,
    input  logic [N_CH-1:0] sync_i,
    output logic [N_CH-1:0] en_o
);

    logic [N_CH-1:0] en_q;

    // Set and sync take priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q & ~clr_i) | set_i | sync_i;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
    parameter int N_CH   = 4,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [N_CH-1:0][INT_W-1:0]   div_int_i,
    input  logic [N_CH-1:0][FRAC_W-1:0]  div_frac_i,
    input  logic [N_CH-1:0]              restart_i,
    input  logic [N_CH-1:0]              en_set_i,
    input  logic [N_CH-1:0]              en_clr_i,
    input  logic [N_CH-1:0]              sync_en_i,
    output logic [N_CH-1:0]              clk_en_o,
    output logic [N_CH-1:0]              tick_o,
    output logic [N_CH-1:0]              eng_en_o
);

    logic [N_CH-1:0] restart_all;
    logic [N_CH-1:0] pulse;
    logic [N_CH-1:0] en;

    assign restart_all = restart_i | sync_en_i;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        clkdiv_chan #(
            .INT_W  (INT_W),
            .FRAC_W (FRAC_W)
        ) chan_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .restart_i  (restart_all[ch]),
            .div_int_i  (div_int_i[ch]),
            .div_frac_i (div_frac_i[ch]),
            .pulse_o    (pulse[ch])
        );
    end

    clkdiv_enable #(
        .N_CH (N_CH)
    ) enable_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (en_set_i),
        .clr_i  (en_clr_i),
        .sync_i (sync_en_i),
        .en_o   (en)
    );

    assign clk_en_o = pulse;
    assign eng_en_o = en;
    assign tick_o   = pulse & en;

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int N_CH   = 4,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic [N_CH-1:0][INT_W-1:0]   div_int_i,
    input logic [N_CH-1:0][FRAC_W-1:0]  div_frac_i,
    input logic [N_CH-1:0]              restart_i,
    input logic [N_CH-1:0]              en_set_i,
    input logic [N_CH-1:0]              en_clr_i,
    input logic [N_CH-1:0]              sync_en_i,
    input logic [N_CH-1:0]              clk_en_o,
    input logic [N_CH-1:0]              eng_en_o
);

    logic [N_CH-1:0] rs;
    assign rs = restart_i | sync_en_i;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        // R2: divisor 1 pulses in cycle 1 after a restart
        assert_first_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rs[ch] && div_int_i[ch] == INT_W'(1)) |=> clk_en_o[ch]);

        // R2: pulse or restart with integer part other than 1 leaves a quiet next cycle
        assert_min_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((rs[ch] || clk_en_o[ch]) && div_int_i[ch] != INT_W'(1)) |=> !clk_en_o[ch]);

        // R4: divisor 1.0 keeps pulsing every cycle
        assert_every_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((rs[ch] || clk_en_o[ch]) && div_int_i[ch] == INT_W'(1)
                && div_frac_i[ch] == '0) |=> clk_en_o[ch]);

        // R9: a clear with no set leaves the bit low
        assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_clr_i[ch] && !en_set_i[ch] && !sync_en_i[ch]) |=> !eng_en_o[ch]);

        // R10: sync-enable raises the enable bit
        assert_sync_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sync_en_i[ch] |=> eng_en_o[ch]);
    end

    if (N_CH >= 2) begin : g_lock
        logic same_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                same_q <= 1'b0;
            end else if (rs[0] && rs[1] && div_int_i[0] == div_int_i[1]
                         && div_frac_i[0] == div_frac_i[1]) begin
                same_q <= 1'b1;
            end else if (rs[0] != rs[1] || div_int_i[0] != div_int_i[1]
                         || div_frac_i[0] != div_frac_i[1]) begin
                same_q <= 1'b0;
            end
        end

        // R7: channels restarted together with equal divisors stay aligned
        assert_lockstep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            same_q |-> (clk_en_o[0] == clk_en_o[1]));
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .N_CH   (N_CH),
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_int_i  (div_int_i),
    .div_frac_i (div_frac_i),
    .restart_i  (restart_i),
    .en_set_i   (en_set_i),
    .en_clr_i   (en_clr_i),
    .sync_en_i  (sync_en_i),
    .clk_en_o   (clk_en_o),
    .eng_en_o   (eng_en_o)
);

// File: tb/clkdiv_bank_tb_top.sv
`timescale 1ns/1ps
module clkdiv_bank_tb_top;

    localparam int N  = 4;
    localparam int IW = 16;
    localparam int FW = 8;
    localparam int W  = 2048;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0][IW-1:0] dint;
    logic [N-1:0][FW-1:0] dfrac;
    logic [N-1:0] rmask, setm, clrm, syncm;
    logic [N-1:0] clk_en, tick, eng_en;

    clkdiv_bank #(.N_CH(N), .INT_W(IW), .FRAC_W(FW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .div_int_i(dint), .div_frac_i(dfrac),
        .restart_i(rmask), .en_set_i(setm), .en_clr_i(clrm), .sync_en_i(syncm),
        .clk_en_o(clk_en), .tick_o(tick), .eng_en_o(eng_en)
    );

    int errors = 0;
    int checks = 0;
    int gc = 0;
    bit done = 0;
    // mode: 0 expect idle, 1 follow schedule, 2 not checked
    int mode [N];
    int org [N], kk [N], nxt [N], ieff [N], fr [N], pcnt [N];
    int mism [N], mgc [N], mact [N], mexp [N];
    int emis = 0;
    int lmis = 0;
    bit lock_on = 0;
    logic [N-1:0] en_m;

    function automatic int sched(int k, int i, int f);
        return k * i + (k * f) / 256;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic arm(int i);
        mode[i] = 1;
        ieff[i] = (dint[i] == 0) ? 65536 : int'(dint[i]);
        fr[i]   = int'(dfrac[i]);
        kk[i]   = 1;
        nxt[i]  = sched(1, ieff[i], fr[i]);
        org[i]  = gc + 1;
        pcnt[i] = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        gc++;
        for (int i = 0; i < N; i++) begin
            bit e;
            e = 1'b0;
            if (mode[i] == 1) begin
                e = ((gc - org[i] + 1) == nxt[i]);
                if (e) begin
                    kk[i]++;
                    nxt[i] = sched(kk[i], ieff[i], fr[i]);
                end
            end
            if (mode[i] != 2 && clk_en[i] !== e) begin
                if (mism[i] == 0) begin
                    mgc[i] = gc - org[i] + 1; mact[i] = int'(clk_en[i]); mexp[i] = int'(e);
                end
                mism[i]++;
            end
            if (clk_en[i] === 1'b1) pcnt[i]++;
        end
        if (eng_en !== en_m || tick !== (clk_en & en_m)) emis++;
        if (lock_on && clk_en[0] !== clk_en[1]) lmis++;
    endtask

    task automatic run(int n);
        for (int j = 0; j < n; j++) cyc();
    endtask

    task automatic restart(logic [N-1:0] m);
        rmask = m;
        for (int i = 0; i < N; i++) if (m[i]) arm(i);
        cyc();
        rmask = '0;
    endtask

    task automatic drive_en(logic [N-1:0] s, logic [N-1:0] c, logic [N-1:0] y);
        setm = s; clrm = c; syncm = y;
        for (int i = 0; i < N; i++) if (y[i]) arm(i);
        en_m = (en_m & ~c) | s | y;
        cyc();
        setm = '0; clrm = '0; syncm = '0;
    endtask

    task automatic end_seg(string req);
        for (int i = 0; i < N; i++) begin
            if (mode[i] != 2)
                check(mism[i] == 0, req, $sformatf("ch%0d pulse in cycle %0d", i, mgc[i]),
                      mact[i], mexp[i]);
            mism[i] = 0;
        end
        check(emis == 0, "R8", "enable/tick mismatch cycles", emis, 0);
        emis = 0;
    endtask

    initial begin
        rmask = '0; setm = '0; clrm = '0; syncm = '0; en_m = '0;
        for (int i = 0; i < N; i++) begin
            dint[i] = IW'(1); dfrac[i] = '0; mode[i] = 0; mism[i] = 0;
        end
        // R1: during and after reset, no output until a restart
        run(4);
        check(clk_en == '0 && tick == '0 && eng_en == '0, "R1", "outputs in reset",
              int'({clk_en, tick, eng_en}), 0);
        rst_n = 1'b1;
        run(20);
        end_seg("R1");

        // R2 R4 R5 R7: sweep of divisors, all channels restarted together
        for (int c = 0; c < 6; c++) begin
            dint[0]  = IW'(1 + c);          dfrac[0] = FW'((c * 73 + 128) % 256);
            dint[1]  = dint[0];             dfrac[1] = dfrac[0];
            dint[2]  = IW'(2 + 3 * c);      dfrac[2] = (c == 3) ? FW'(0) : FW'(255 - 45 * c);
            dint[3]  = IW'(1);              dfrac[3] = '0;
            lock_on = 1; lmis = 0;
            restart('1);
            run(W - 1);
            end_seg("R2");
            check(lmis == 0, "R7", "ch0/ch1 differing cycles", lmis, 0);
            check(pcnt[3] == W, "R4", "pulses at divisor 1.0", pcnt[3], W);
            for (int i = 0; i < 3; i++) begin
                int q;
                q = (W * 256) / (ieff[i] * 256 + fr[i]);
                check(pcnt[i] >= q - 1 && pcnt[i] <= q + 1, "R5",
                      $sformatf("cfg%0d ch%0d pulse count", c, i), pcnt[i], q);
            end
        end
        lock_on = 0;

        // R6: restart a single channel while the rest keep their phase
        for (int i = 0; i < N; i++) begin dint[i] = IW'(5); dfrac[i] = '0; end
        restart('1);
        run(6);
        restart(4'b0001);
        run(30);
        end_seg("R6");

        // R8: disable and re-enable keeps phase and lockstep
        for (int i = 0; i < N; i++) begin dint[i] = IW'(3); dfrac[i] = FW'(64); end
        lock_on = 1; lmis = 0;
        restart('1);
        drive_en('1, '0, '0);
        run(20);
        drive_en('0, 4'b0001, '0);
        run(37);
        check(eng_en[0] == 1'b0 && tick[0] == 1'b0, "R8", "disabled ch0 tick/enable",
              int'({eng_en[0], tick[0]}), 0);
        drive_en(4'b0001, '0, '0);
        run(30);
        end_seg("R8");
        check(lmis == 0, "R8", "ch0/ch1 differ after re-enable", lmis, 0);
        lock_on = 0;

        // R9: set wins over clear; clears take effect next cycle
        drive_en(4'b0010, 4'b1110, '0);
        check(eng_en == 4'b0011, "R9", "enable after set+clear", int'(eng_en), 3);
        drive_en('0, '1, '0);
        check(eng_en == 4'b0000, "R9", "enable after clear all", int'(eng_en), 0);
        run(5);
        end_seg("R9");

        // R10 R11: sync-enable with a new divisor on ch1 and ch2
        dint[1] = IW'(4); dint[2] = IW'(4); dfrac[1] = '0; dfrac[2] = '0;
        drive_en('0, '0, 4'b0110);
        check(eng_en == 4'b0110, "R10", "enable after sync", int'(eng_en), 6);
        check(clk_en[1] == 1'b0 && clk_en[2] == 1'b0, "R10", "cycle 1 after sync",
              int'({clk_en[1], clk_en[2]}), 0);
        run(3);
        check(clk_en[1] == 1'b1 && clk_en[2] == 1'b1, "R10", "cycle 4 after sync",
              int'({clk_en[1], clk_en[2]}), 3);
        run(20);
        end_seg("R10");

        // R11: change divisor mid-period; applies at next boundary
        begin
            logic [20:1] act, exp;
            dint[0] = IW'(3); dfrac[0] = '0;
            restart(4'b0001);
            mode[0] = 2;
            act = '0;
            act[1] = clk_en[0];
            for (int n = 2; n <= 20; n++) begin
                if (n == 5) dint[0] = IW'(5);
                cyc();
                act[n] = clk_en[0];
            end
            exp = '0;
            exp[3] = 1'b1; exp[6] = 1'b1; exp[11] = 1'b1; exp[16] = 1'b1;
            check(act == exp, "R11", "pulse pattern cycles 1..20", int'(act), int'(exp));
            end_seg("R11");
        end

        // R3: integer part 0 means a 65536-cycle period
        dint[3] = '0; dfrac[3] = '0;
        restart(4'b1000);
        run(65535);
        check(pcnt[3] == 1, "R3", "pulses by cycle 65536", pcnt[3], 1);
        run(4);
        end_seg("R3");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule